// File: doc/BRIEF.md
# UART Receive Buffer with Hysteresis Flow Control

This block sits between a serial receiver's deserializer and the host side of a UART. Each completed character arrives as an 8-bit byte plus three error tags, and the block keeps them together in a 64-entry first-in first-out store. The host sees the oldest character and its tags on the read side. It also sees the fill count and a data-ready interrupt that rises once the count reaches a programmable trigger.

When automatic flow control is switched on, an active-low request line tells the remote transmitter whether it may keep sending. The line goes high when the fill level climbs to the trigger plus a hysteresis margin. It goes low again only when the level has drained to the trigger minus the margin. Between those two marks it holds its last state, so the line does not chatter around a single threshold.

With buffering disabled, the block behaves as a one-character holding register. Disabling buffering also discards everything stored.

Top module: `uart_rx_buffer`

## Requirements
- R1: The store keeps up to 64 characters, each with its 3 error tags. Characters come out in arrival order with the tags they arrived with, and the fill count never exceeds 64.
- R2: The line flags are laid out as follows. Bit 0 is high exactly when the fill count is nonzero. Bits 3 to 1 show the error tags of the head character, and they read 0 when the store is empty.
- R3: With buffering on, the interrupt is high exactly while the fill count is at or above the effective trigger. A trigger of 0 counts as 1, and a trigger above 64 counts as 64.
- R4: With flow control active, the request output goes high in the cycle after the fill count is at or above the upper mark. The upper mark is trigger plus hysteresis, limited to 64.
- R5: With flow control active, the request output goes low in the cycle after the fill count is at or below the lower mark. The lower mark is trigger minus hysteresis, not less than 0. Between the two marks the output keeps its value.
- R6: Flow control is active only while both the feature-enable input and the modem-select input are 1. Otherwise the request output is low from the next cycle on. After reset it is low.
- R7: With buffering off, the block holds at most one character. A second character is dropped, and the interrupt is high whenever a character is held.
- R8: A character that arrives while the store is full is dropped and sets line flag bit 4 in the next cycle. The bit stays set until a status-read pulse clears it; a new drop in the same cycle wins.
- R9: A write and a read in the same cycle leave the count unchanged. A read of an empty store leaves the count at 0, and the data output then shows the last character read.
- R10: Changing buffering from on to off empties the store in the next cycle, with the count at 0 and the interrupt low.
- R11: After reset the fill count, the interrupt, the request output and all line flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = buffering, 0 = single holding register |
| trig_lvl | input | 7 | Receive trigger level |
| hyst_lvl | input | 7 | Hysteresis margin around the trigger |
| afc_feat_en | input | 1 | Enhanced-feature enable for flow control |
| afc_sel | input | 1 | Modem-control select for flow control |
| ch_valid | input | 1 | One-cycle strobe: a received character is present |
| ch_data | input | 8 | Received byte |
| ch_err | input | 3 | Error tags of the received byte |
| rd_en | input | 1 | Host read strobe, pops the head character |
| stat_rd | input | 1 | Host status read, clears the overrun flag |
| rd_data | output | 8 | Head character, or the last read one when empty |
| line_flags | output | 5 | {overrun, head tags[2:0], data ready} |
| fill_cnt | output | 7 | Number of stored characters |
| rx_irq | output | 1 | Receive data interrupt |
| rts_n | output | 1 | Active-low request-to-send / terminal-ready |

## Verification
A read pointer that is off by one shows up at the very next host read, as a byte or tag set out of arrival order. A count that drifts from the real occupancy shows up in the same cycle on the fill output, the data-ready flag and the interrupt. It also shows up a cycle later on the request line, because that line is registered from the count. A lost hysteresis state is visible only while the level sits between the two marks, so the bench parks the level just above the lower mark on the way down and checks that the line has stayed high.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  localparam int DATA_W = 8;
  localparam int ERR_W  = 3;

  typedef struct packed {
    logic [ERR_W-1:0]  err;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  // saturate a value at a limit
  function automatic int unsigned cap_at(input int unsigned v, input int unsigned lim);
    return (v > lim) ? lim : v;
  endfunction

  // trigger actually compared against the fill count
  function automatic int unsigned eff_trigger(input int unsigned t, input int unsigned depth);
    return (t == 0) ? 1 : cap_at(t, depth);
  endfunction

  // mark at which the remote sender is told to pause
  function automatic int unsigned upper_mark(input int unsigned t, input int unsigned h,
                                             input int unsigned depth);
    return cap_at(t + h, depth);
  endfunction

  // mark at which the remote sender is told to resume
  function automatic int unsigned lower_mark(input int unsigned t, input int unsigned h,
                                             input int unsigned depth);
    return (t > h) ? cap_at(t - h, depth) : 0;
  endfunction

endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store
  import rxbuf_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              single,
  input  logic              flush,
  input  logic              wr_req,
  input  rx_entry_t         wr_ent,
  input  logic              rd_req,
  input  logic              ovr_clr,
  output rx_entry_t         head_ent,
  output logic [DATA_W-1:0] last_data,
  output logic [CW-1:0]     count,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic              drop,
  output logic              overrun
);

  rx_entry_t      mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic           empty, full;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = single ? !empty : (count == CW'(DEPTH));
  assign wr_ok = wr_req && !full && !flush;
  assign rd_ok = rd_req && !empty && !flush;
  assign drop  = wr_req && full && !flush;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_ent;
  end

  assign head_ent = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wp <= bump(wp);
      if (rd_ok) rp <= bump(rp);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_data <= '0;
    else if (rd_ok) last_data <= head_ent.data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (drop)    overrun <= 1'b1;
    else if (ovr_clr) overrun <= 1'b0;
  end

endmodule

// File: rtl/rxbuf_thresh.sv
module rxbuf_thresh
  import rxbuf_pkg::*;
#(
  parameter  int DEPTH = 64,
  parameter  int TW    = 7,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_en,
  input  logic          afc_on,
  input  logic [TW-1:0] trig,
  input  logic [TW-1:0] hyst,
  input  logic [CW-1:0] count,
  output logic          irq,
  output logic          rts_n,
  output logic [CW-1:0] hi_thr,
  output logic [CW-1:0] lo_thr
);

  int unsigned cnt_u, trig_e, hi_u, lo_u;

  always_comb begin
    cnt_u  = 32'(count);
    trig_e = eff_trigger(32'(trig), DEPTH);
    hi_u   = upper_mark(32'(trig), 32'(hyst), DEPTH);
    lo_u   = lower_mark(32'(trig), 32'(hyst), DEPTH);
  end

  assign hi_thr = CW'(hi_u);
  assign lo_thr = CW'(lo_u);
  assign irq    = buf_en ? (cnt_u >= trig_e) : (cnt_u != 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rts_n <= 1'b0;
    else if (!afc_on)        rts_n <= 1'b0;
    else if (cnt_u >= hi_u)  rts_n <= 1'b1;
    else if (cnt_u <= lo_u)  rts_n <= 1'b0;
  end

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import rxbuf_pkg::*;
#(
  parameter  int DEPTH = 64,
  parameter  int TW    = 7,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [TW-1:0]     trig_lvl,
  input  logic [TW-1:0]     hyst_lvl,
  input  logic              afc_feat_en,
  input  logic              afc_sel,
  input  logic              ch_valid,
  input  logic [DATA_W-1:0] ch_data,
  input  logic [ERR_W-1:0]  ch_err,
  input  logic              rd_en,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic [ERR_W+1:0]  line_flags,
  output logic [CW-1:0]     fill_cnt,
  output logic              rx_irq,
  output logic              rts_n
);

  // named internal events
  logic       en_q, flush, afc_on;
  logic       wr_ok, rd_ok, drop, overrun, ready;
  logic [CW-1:0] hi_thr, lo_thr;
  rx_entry_t  head_ent;
  logic [DATA_W-1:0] last_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= fifo_en;
  end

  assign flush  = en_q && !fifo_en;
  assign afc_on = afc_feat_en && afc_sel;

  rxbuf_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .single    (!fifo_en),
    .flush     (flush),
    .wr_req    (ch_valid),
    .wr_ent    ('{err: ch_err, data: ch_data}),
    .rd_req    (rd_en),
    .ovr_clr   (stat_rd),
    .head_ent  (head_ent),
    .last_data (last_data),
    .count     (fill_cnt),
    .wr_ok     (wr_ok),
    .rd_ok     (rd_ok),
    .drop      (drop),
    .overrun   (overrun)
  );

  rxbuf_thresh #(.DEPTH(DEPTH), .TW(TW)) u_thresh (
    .clk    (clk),
    .rst_n  (rst_n),
    .buf_en (fifo_en),
    .afc_on (afc_on),
    .trig   (trig_lvl),
    .hyst   (hyst_lvl),
    .count  (fill_cnt),
    .irq    (rx_irq),
    .rts_n  (rts_n),
    .hi_thr (hi_thr),
    .lo_thr (lo_thr)
  );

  assign ready      = (fill_cnt != '0);
  assign rd_data    = ready ? head_ent.data : last_data;
  assign line_flags = {overrun, (ready ? head_ent.err : '0), ready};

endmodule

// File: rtl/uart_rx_buffer_chk.sv
module uart_rx_buffer_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          afc_on,
  input logic          rd_en,
  input logic [CW-1:0] fill_cnt,
  input logic [CW-1:0] hi_thr,
  input logic [CW-1:0] lo_thr,
  input logic          rx_irq,
  input logic          rts_n,
  input logic          overrun,
  input logic          wr_ok,
  input logic          rd_ok,
  input logic          flush,
  input logic          drop
);

  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH));

  assert_rts_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (afc_on && fill_cnt >= hi_thr) |=> rts_n);

  assert_rts_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (afc_on && fill_cnt <= lo_thr && fill_cnt < hi_thr) |=> !rts_n);

  assert_rts_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (afc_on && fill_cnt > lo_thr && fill_cnt < hi_thr) |=> (rts_n == $past(rts_n)));

  assert_afc_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !afc_on |=> !rts_n);

  assert_hold_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && fill_cnt != '0) |-> rx_irq);

  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overrun);

  assert_pair_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && rd_ok && !flush) |=> $stable(fill_cnt));

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fill_cnt == '0 && !wr_ok && !flush) |=> (fill_cnt == '0));

  assert_flush_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill_cnt == '0 && !rx_irq));

endmodule

bind uart_rx_buffer uart_rx_buffer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fifo_en  (fifo_en),
  .afc_on   (afc_on),
  .rd_en    (rd_en),
  .fill_cnt (fill_cnt),
  .hi_thr   (hi_thr),
  .lo_thr   (lo_thr),
  .rx_irq   (rx_irq),
  .rts_n    (rts_n),
  .overrun  (line_flags[4]),
  .wr_ok    (wr_ok),
  .rd_ok    (rd_ok),
  .flush    (flush),
  .drop     (drop)
);

// File: tb/uart_rx_buffer_test.sv
module uart_rx_buffer_test;

  logic       clk = 1'b0;
  logic       rst_n, fifo_en, afc_feat_en, afc_sel, ch_valid, rd_en, stat_rd;
  logic [6:0] trig_lvl, hyst_lvl;
  logic [7:0] ch_data, rd_data;
  logic [2:0] ch_err;
  logic [4:0] line_flags;
  logic [6:0] fill_cnt;
  logic       rx_irq, rts_n;

  always #5 clk = ~clk;

  uart_rx_buffer uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_lvl(trig_lvl), .hyst_lvl(hyst_lvl),
    .afc_feat_en(afc_feat_en), .afc_sel(afc_sel), .ch_valid(ch_valid), .ch_data(ch_data),
    .ch_err(ch_err), .rd_en(rd_en), .stat_rd(stat_rd), .rd_data(rd_data),
    .line_flags(line_flags), .fill_cnt(fill_cnt), .rx_irq(rx_irq), .rts_n(rts_n)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cap   = 1;
  logic [10:0] sb[$];          // expected {err, data} in arrival order
  logic [7:0]  last_rd = 8'h00;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  // driver: one character strobe; the scoreboard keeps what should be accepted
  task automatic put(input logic [7:0] d, input logic [2:0] e);
    ch_valid = 1'b1; ch_data = d; ch_err = e;
    if (sb.size() < cap) sb.push_back({e, d});
    @(negedge clk);
    ch_valid = 1'b0;
  endtask

  task automatic rd();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic put_rd(input logic [7:0] d, input logic [2:0] e);
    ch_valid = 1'b1; ch_data = d; ch_err = e; rd_en = 1'b1;
    if (sb.size() < cap) sb.push_back({e, d});
    @(negedge clk);
    ch_valid = 1'b0; rd_en = 1'b0;
  endtask

  task automatic status_read();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  // monitor: compares the head against the scoreboard whenever a read is issued
  always begin
    @(negedge clk);
    #3;
    if (rst_n && rd_en) begin
      if (sb.size() > 0) begin
        logic [10:0] exp_e;
        exp_e = sb.pop_front();
        chk("R1 head data order", int'(rd_data), int'(exp_e[7:0]));
        chk("R2 head tags in flags 3:1", int'(line_flags[3:1]), int'(exp_e[10:8]));
        chk("R2 ready flag", int'(line_flags[0]), 1);
        last_rd = exp_e[7:0];
      end else begin
        chk("R9 empty read shows last data", int'(rd_data), int'(last_rd));
        chk("R2 empty tags zero", int'(line_flags[3:1]), 0);
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; fifo_en = 1'b0; afc_feat_en = 1'b0; afc_sel = 1'b0;
    ch_valid = 1'b0; rd_en = 1'b0; stat_rd = 1'b0;
    trig_lvl = 7'd0; hyst_lvl = 7'd0; ch_data = 8'h00; ch_err = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();

    // R11 reset state
    chk("R11 fill after reset", int'(fill_cnt), 0);
    chk("R11 irq after reset", int'(rx_irq), 0);
    chk("R11 rts_n after reset", int'(rts_n), 0);
    chk("R11 flags after reset", int'(line_flags), 0);

    // trigger crossing, ordering, paired access, empty read
    fifo_en = 1'b1; cap = 64; trig_lvl = 7'd4; hyst_lvl = 7'd2;
    idle();
    for (int i = 0; i < 3; i++) put(8'h30 + 8'(i), 3'(i + 1));
    chk("R3 below trigger", int'(rx_irq), 0);
    put(8'h41, 3'b101);
    chk("R3 at trigger", int'(rx_irq), 1);
    chk("R1 count four", int'(fill_cnt), 4);
    rd(); rd();
    chk("R3 under trigger after reads", int'(rx_irq), 0);
    put_rd(8'h55, 3'b010);
    chk("R9 paired access count", int'(fill_cnt), 2);
    rd(); rd();
    chk("R2 ready low when empty", int'(line_flags[0]), 0);
    rd();
    chk("R9 empty read count", int'(fill_cnt), 0);

    // hysteresis band: trigger 48, margin 8
    trig_lvl = 7'd48; hyst_lvl = 7'd8; afc_feat_en = 1'b1; afc_sel = 1'b1;
    for (int i = 0; i < 55; i++) put(8'(i * 37 + 5), 3'(i));
    idle();
    chk("R4 rts_n low at 55", int'(rts_n), 0);
    chk("R3 irq at 55", int'(rx_irq), 1);
    put(8'hA5, 3'b111);
    idle();
    chk("R4 rts_n high at 56", int'(rts_n), 1);
    for (int i = 56; i < 64; i++) put(8'(i * 11), 3'(i + 3));
    chk("R1 full count", int'(fill_cnt), 64);
    put(8'hEE, 3'b001);
    chk("R8 drop keeps count", int'(fill_cnt), 64);
    chk("R8 overrun flag set", int'(line_flags[4]), 1);
    status_read();
    chk("R8 overrun cleared", int'(line_flags[4]), 0);
    for (int i = 0; i < 23; i++) rd();
    idle();
    chk("R5 rts_n held at 41", int'(rts_n), 1);
    chk("R3 irq low at 41", int'(rx_irq), 0);
    rd();
    idle();
    chk("R5 rts_n low at 40", int'(rts_n), 0);

    // gating of flow control
    afc_sel = 1'b0;
    for (int i = 0; i < 20; i++) put(8'(i + 100), 3'(i + 5));
    idle();
    chk("R6 inactive without select", int'(rts_n), 0);
    afc_sel = 1'b1;
    idle();
    chk("R6 active with both bits", int'(rts_n), 1);
    afc_feat_en = 1'b0;
    idle();
    chk("R6 inactive without feature bit", int'(rts_n), 0);

    // flush on disable
    fifo_en = 1'b0; cap = 1;
    sb.delete();
    idle();
    chk("R10 flushed count", int'(fill_cnt), 0);
    chk("R10 irq cleared", int'(rx_irq), 0);

    // single holding register
    put(8'h5A, 3'b100);
    chk("R7 one held", int'(fill_cnt), 1);
    chk("R7 irq on one char", int'(rx_irq), 1);
    put(8'hC3, 3'b011);
    chk("R7 second char dropped", int'(fill_cnt), 1);
    chk("R8 overrun in single mode", int'(line_flags[4]), 1);
    rd();
    chk("R7 empty after read", int'(fill_cnt), 0);
    status_read();

    // trigger clamping
    fifo_en = 1'b1; cap = 64; trig_lvl = 7'd0;
    idle();
    put(8'h11, 3'b000);
    chk("R3 zero trigger acts as one", int'(rx_irq), 1);
    trig_lvl = 7'd100;
    idle();
    chk("R3 large trigger acts as 64", int'(rx_irq), 0);
    rd();

    // upper mark clamped to 64
    trig_lvl = 7'd60; hyst_lvl = 7'd20; afc_feat_en = 1'b1; afc_sel = 1'b1;
    for (int i = 0; i < 63; i++) put(8'(i * 3), 3'(i));
    idle();
    chk("R4 clamped mark not reached at 63", int'(rts_n), 0);
    put(8'h77, 3'b110);
    idle();
    chk("R4 clamped mark reached at 64", int'(rts_n), 1);
    chk("R3 irq at 64", int'(rx_irq), 1);

    summary();
    $finish;
  end

endmodule